// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management-interface master for an Ethernet PHY. Software writes one 32-bit command word that holds the PHY address, the register address, a read/write opcode and 16 bits of write data. The controller then sends a complete Clause 22 MDIO frame on a serial clock and data pair. It produces the serial clock MDC from the system clock, and it turns the data line around during reads.

Software reads the same command word to follow the transaction. A busy flag stays high while the frame is on the wire. A read-valid flag goes high once the low 16 bits hold the data returned by the PHY. A second register beside the command register holds a 5-bit local PHY address that the block stores but does not otherwise use.

Top module: `mgmt_cmd_ctrl`

## Requirements
- R1: The command register (reg_addr = 0) decodes write data in bits [15:0], PHY address in bits [20:16], register address in bits [25:21] and the opcode in bit 26 (1 = read, 0 = write). Reading it returns these fields, plus the read-valid flag in bit 27 and the busy flag in bit 28. Bits [31:29] read as zero.
- R2: The PHY-address register (reg_addr = 1) stores only write-data bits [4:0], and it reads back with bits [31:5] at zero.
- R3: MDC is low after reset and toggles every CLK_DIV_HALF system clocks. Its period is 2*CLK_DIV_HALF clocks.
- R4: The read-valid flag is set when a read frame completes, and it clears in the cycle after a new command is accepted.
- R5: Busy is set in the cycle after a command write is accepted, and it clears after the last frame bit. A command write while busy is high changes no field and does not alter the frame in progress.
- R6: A write frame is 32 ones, then 01, then opcode 01, then the PHY address, then the register address, then turnaround 10, then the 16 data bits. All fields are sent MSB first, and mdio_oe is high for all 64 bits.
- R7: A read frame sends opcode 10. mdio_oe is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled on the rising edge of MDC, MSB first, and they appear in command bits [15:0] when busy clears.
- R8: mdio_out and mdio_oe change only at falling edges of MDC.
- R9: After reset both registers read zero and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = command, 1 = PHY address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_in | input | 1 | Serial data from the MDIO pad |

## Verification
A wrong bit index or shift position in the frame engine shows up at the first MDC rising edge where the affected bit is sent. The bench compares every transmitted bit and every enable value at each MDC rise, so a corrupted field is caught within one MDC period of the point where it goes wrong. A bad divider count shows up as an MDC mismatch within one clock, because MDC is compared against an independent count on every cycle. A wrong state in the status logic shows up as a busy or read-valid value that does not match. This includes a late flag, a sticky flag, or a command that is not ignored while busy. The bench reads these at the port one cycle after the accepting write and within a few clocks of the end of the frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int WORD_W    = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;   // first turnaround bit
    localparam int DATA_POS  = TA_POS + 2;                  // first data bit
    localparam int PHY_LSB   = 16;
    localparam int REG_LSB   = 21;
    localparam int OP_BIT    = 26;
    localparam int VALID_BIT = 27;
    localparam int BUSY_BIT  = 28;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mgmt_op_e;

    typedef struct packed {
        mgmt_op_e            op;
        logic [ADDR_W-1:0]   reg_addr;
        logic [ADDR_W-1:0]   phy_addr;
        logic [DATA_W-1:0]   data;
    } mgmt_cmd_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_WAIT,
        ENG_SHIFT
    } eng_state_e;

    function automatic mgmt_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        mgmt_cmd_t c;
        c.op       = mgmt_op_e'(w[OP_BIT]);
        c.reg_addr = w[REG_LSB +: ADDR_W];
        c.phy_addr = w[PHY_LSB +: ADDR_W];
        c.data     = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input mgmt_cmd_t c,
                                                      input logic busy,
                                                      input logic valid);
        logic [WORD_W-1:0] w;
        w                       = '0;
        w[DATA_W-1:0]           = c.data;
        w[PHY_LSB +: ADDR_W]    = c.phy_addr;
        w[REG_LSB +: ADDR_W]    = c.reg_addr;
        w[OP_BIT]               = c.op;
        w[VALID_BIT]            = valid;
        w[BUSY_BIT]             = busy;
        return w;
    endfunction

    // Bit image of the frame, first bit sent at the MSB.
    function automatic logic [FRAME_LEN-1:0] build_frame(input mgmt_cmd_t c);
        logic [1:0] opc;
        logic [1:0] ta;
        opc = (c.op == OP_READ) ? 2'b10 : 2'b01;
        ta  = (c.op == OP_READ) ? 2'b11 : 2'b10;
        return {{PRE_LEN{1'b1}}, 2'b01, opc, c.phy_addr, c.reg_addr, ta,
                (c.op == OP_READ) ? {DATA_W{1'b1}} : c.data};
    endfunction

    // Per-bit drive enable, aligned with build_frame.
    function automatic logic [FRAME_LEN-1:0] build_mask(input mgmt_op_e op);
        logic [FRAME_LEN-1:0] m;
        m = '1;
        if (op == OP_READ) begin
            for (int i = 0; i < FRAME_LEN - TA_POS; i++) begin
                m[i] = 1'b0;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = (cnt_q == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (HALF_DIV > 1) begin : g_hold_chk
            // R3: a toggle of MDC is never followed by another one in the next cycle
            a_r3_mdc_half_period: assert property (@(posedge clk) disable iff (rst)
                !$stable(mdc) |=> $stable(mdc));
        end
    endgenerate

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
    import mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  mgmt_cmd_t          cmd_in,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_in,
    output logic               mdio_out,
    output logic               mdio_oe,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_POS);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);

    eng_state_e             state_q;
    logic [FRAME_LEN-1:0]   frame_q;
    logic [FRAME_LEN-1:0]   mask_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   is_read_q;
    logic [DATA_W-1:0]      rd_q;

    assign rd_data = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            frame_q   <= '0;
            mask_q    <= '0;
            idx_q     <= '0;
            is_read_q <= 1'b0;
            rd_q      <= '0;
            mdio_out  <= 1'b0;
            mdio_oe   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        frame_q   <= build_frame(cmd_in);
                        mask_q    <= build_mask(cmd_in.op);
                        is_read_q <= (cmd_in.op == OP_READ);
                        state_q   <= ENG_WAIT;
                    end
                end
                ENG_WAIT: begin
                    if (fall_tick) begin
                        mdio_out <= frame_q[FRAME_LEN-1];
                        mdio_oe  <= mask_q[FRAME_LEN-1];
                        idx_q    <= '0;
                        state_q  <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_tick && is_read_q && (idx_q >= IDX_DATA)) begin
                        rd_q <= {rd_q[DATA_W-2:0], mdio_in};
                    end
                    if (fall_tick) begin
                        if (idx_q == IDX_LAST) begin
                            mdio_oe  <= 1'b0;
                            mdio_out <= 1'b0;
                            done     <= 1'b1;
                            state_q  <= ENG_IDLE;
                        end else begin
                            mdio_out <= frame_q[FRAME_LEN-2];
                            mdio_oe  <= mask_q[FRAME_LEN-2];
                            frame_q  <= frame_q << 1;
                            mask_q   <= mask_q << 1;
                            idx_q    <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R8: serial outputs move only on a falling MDC edge
    a_r8_out_at_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_out) |-> $past(fall_tick));
    a_r8_oe_at_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> $past(fall_tick));
    // R7: during a read the line is released from turnaround to the end
    a_r7_released: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_SHIFT && is_read_q && idx_q >= IDX_TA) |-> !mdio_oe);

endmodule

// File: rtl/mgmt_cmd_ctrl.sv
module mgmt_cmd_ctrl
    import mgmt_pkg::*;
#(
    parameter int CLK_DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    mgmt_cmd_t           cmd_q;
    mgmt_cmd_t           cmd_new;
    logic                busy_q;
    logic                valid_q;
    logic [ADDR_W-1:0]   local_phy_q;
    logic                accept;
    logic                rise_tick;
    logic                fall_tick;
    logic                eng_done;
    logic [DATA_W-1:0]   eng_rd_data;

    assign cmd_new = unpack_cmd(reg_wdata);
    assign accept  = reg_wr && !reg_addr && !busy_q;

    mgmt_mdc_gen #(.HALF_DIV(CLK_DIV_HALF)) i_mdc_gen (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mgmt_frame_engine i_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .cmd_in    (cmd_new),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (eng_done),
        .rd_data   (eng_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= '0;
            busy_q      <= 1'b0;
            valid_q     <= 1'b0;
            local_phy_q <= '0;
        end else begin
            if (reg_wr && reg_addr) begin
                local_phy_q <= reg_wdata[ADDR_W-1:0];
            end
            if (accept) begin
                cmd_q   <= cmd_new;
                busy_q  <= 1'b1;
                valid_q <= 1'b0;
            end else if (eng_done) begin
                busy_q <= 1'b0;
                if (cmd_q.op == OP_READ) begin
                    cmd_q.data <= eng_rd_data;
                    valid_q    <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (reg_addr) begin
            reg_rdata = {{(WORD_W-ADDR_W){1'b0}}, local_phy_q};
        end else begin
            reg_rdata = pack_status(cmd_q, busy_q, valid_q);
        end
    end

    // R5: a command write while busy leaves the stored command unchanged
    a_r5_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (busy_q && reg_wr && !reg_addr && !eng_done) |=> $stable(cmd_q));
    // R4, R5: an accepted command raises busy and drops read-valid
    a_r4_valid_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !busy_q) |=> (busy_q && !valid_q));
    // R6: the pad is driven only inside a transaction
    a_r6_oe_in_frame: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy_q);

endmodule

// File: tb/test_mgmt_cmd_ctrl.sv
module test_mgmt_cmd_ctrl;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mgmt_cmd_ctrl #(.CLK_DIV_HALF(HALF)) i_mgmt_cmd_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", 64'(cycles), 64'd150000);
            finish_up();
        end
    end

    // R3 reference: MDC level from an independent cycle count
    int  m_cnt = 0;
    bit  m_mdc = 1'b0;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_mdc = 1'b0;
        end else begin
            m_cnt++;
            if (m_cnt == HALF) begin
                m_cnt = 0;
                m_mdc = ~m_mdc;
            end
        end
    end

    // Frame reference: expected bits and enables, PHY responder
    logic [63:0] e_bits;
    logic [63:0] e_oe;
    logic [15:0] phy_data;
    bit          armed = 1'b0;
    bit          rd_frame = 1'b0;
    int          bitpos = -1;
    int          frames_seen = 0;
    bit          prev_mdc = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(mdc === m_mdc, "R3 mdc level", 64'(mdc), 64'(m_mdc));
            if (mdc && !prev_mdc) begin
                if (armed && bitpos < 0 && mdio_oe) bitpos = 0;
                if (bitpos >= 0) begin
                    chk(mdio_oe === e_oe[63-bitpos],
                        rd_frame ? "R7 enable per bit" : "R6 enable per bit",
                        64'(mdio_oe), 64'(e_oe[63-bitpos]));
                    if (e_oe[63-bitpos])
                        chk(mdio_out === e_bits[63-bitpos],
                            rd_frame ? "R7 frame bit" : "R6 frame bit",
                            64'(mdio_out), 64'(e_bits[63-bitpos]));
                    if (rd_frame && bitpos >= 47 && bitpos < 63)
                        mdio_in = phy_data[62-bitpos];
                    bitpos++;
                    if (bitpos == 64) begin
                        bitpos = -1;
                        armed = 1'b0;
                        mdio_in = 1'b1;
                        frames_seen++;
                    end
                end else begin
                    chk(mdio_oe === 1'b0, "R6 idle line released", 64'(mdio_oe), 64'd0);
                end
            end
        end
        prev_mdc = mdc;
    end

    task automatic wr_reg(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {5'b0, rd, ra, pa, d};
    endfunction

    // Issues a command, checks the frame through the monitor and the status after it
    task automatic run_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input logic [15:0] pd);
        int seen;
        int waitc;
        e_bits   = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
        e_oe     = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        phy_data = pd;
        rd_frame = rd;
        armed    = 1'b1;
        seen     = frames_seen;
        wr_reg(1'b0, mk_cmd(rd, pa, ra, d));
        // Sampled one cycle after the accepting edge
        chk(reg_rdata[28] === 1'b1, "R5 busy after accept", 64'(reg_rdata[28]), 64'd1);
        chk(reg_rdata[27] === 1'b0, "R4 valid cleared by new command", 64'(reg_rdata[27]), 64'd0);
        chk(reg_rdata[26:16] === {rd, ra, pa}, "R1 fields read back",
            64'(reg_rdata[26:16]), 64'({rd, ra, pa}));
        while (frames_seen == seen) @(negedge clk);
        waitc = 0;
        while (reg_rdata[28] && waitc < 3 * HALF) begin
            @(negedge clk);
            waitc++;
        end
        chk(reg_rdata[28] === 1'b0, "R5 busy clears after frame", 64'(reg_rdata[28]), 64'd0);
        chk(reg_rdata[27] === rd, "R4 valid after read only", 64'(reg_rdata[27]), 64'(rd));
        chk(reg_rdata[15:0] === (rd ? pd : d),
            rd ? "R7 read data captured" : "R1 write data kept",
            64'(reg_rdata[15:0]), 64'(rd ? pd : d));
        chk(reg_rdata[31:29] === 3'b0, "R1 top bits zero", 64'(reg_rdata[31:29]), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(reg_rdata === 32'd0, "R9 command reg after reset", 64'(reg_rdata), 64'd0);
        chk(mdio_oe === 1'b0, "R9 enable after reset", 64'(mdio_oe), 64'd0);
        chk(mdc === 1'b0, "R3 mdc low in reset", 64'(mdc), 64'd0);
        reg_addr = 1'b1;
        #1;
        chk(reg_rdata === 32'd0, "R9 phy reg after reset", 64'(reg_rdata), 64'd0);
        reg_addr = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R2: local PHY address register keeps only 5 bits
        wr_reg(1'b1, 32'hFFFF_FFE5);
        reg_addr = 1'b1;
        #1;
        chk(reg_rdata === 32'h5, "R2 five-bit store", 64'(reg_rdata), 64'h5);
        reg_addr = 1'b0;
        #1;
        chk(reg_rdata === 32'd0, "R2 command reg untouched", 64'(reg_rdata), 64'd0);

        // R6: write frames with distinct patterns
        run_cmd(1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0000);
        run_cmd(1'b0, 5'h1F, 5'h1F, 16'h0001, 16'h0000);
        // R7: read frames
        run_cmd(1'b1, 5'h12, 5'h02, 16'h0000, 16'h8E31);
        run_cmd(1'b1, 5'h00, 5'h15, 16'h0000, 16'hFFFE);
        // R4: a write after a read clears valid (checked inside run_cmd)
        run_cmd(1'b0, 5'h0A, 5'h04, 16'h1234, 16'h0000);

        // R5: a command write during a frame is ignored
        begin
            int seen;
            int waitc;
            e_bits   = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h07, 5'h09, 2'b10, 16'h0};
            e_oe     = {{46{1'b1}}, 18'b0};
            phy_data = 16'h5AA5;
            rd_frame = 1'b1;
            armed    = 1'b1;
            seen     = frames_seen;
            wr_reg(1'b0, mk_cmd(1'b1, 5'h07, 5'h09, 16'h0));
            repeat (100) @(negedge clk);
            wr_reg(1'b0, mk_cmd(1'b0, 5'h1C, 5'h03, 16'hDEAD));
            chk(reg_rdata[26:16] === {1'b1, 5'h09, 5'h07}, "R5 busy write ignored",
                64'(reg_rdata[26:16]), 64'({1'b1, 5'h09, 5'h07}));
            chk(reg_rdata[28] === 1'b1, "R5 still busy", 64'(reg_rdata[28]), 64'd1);
            while (frames_seen == seen) @(negedge clk);
            waitc = 0;
            while (reg_rdata[28] && waitc < 3 * HALF) begin
                @(negedge clk);
                waitc++;
            end
            chk(reg_rdata[15:0] === 16'h5AA5, "R5 frame intact after ignored write",
                64'(reg_rdata[15:0]), 64'h5AA5);
            chk(reg_rdata[27] === 1'b1, "R4 valid set", 64'(reg_rdata[27]), 64'd1);
        end

        reg_addr = 1'b1;
        #1;
        chk(reg_rdata === 32'h5, "R2 value held across frames", 64'(reg_rdata), 64'h5);
        reg_addr = 1'b0;
        repeat (10) @(negedge clk);
        finish_up();
    end
endmodule